// File: doc/BRIEF.md
# Infrared RC-5 Bi-phase Frame Receiver

The receiver takes the digitised output of an infrared detector, where a high level means carrier present (a mark) and a low level means no carrier (a space). The level is brought into the clock domain by a short flop chain. A saturating counter measures how many cycles each mark and space lasts. When the level changes, the length of the interval that has just ended is classified in units of half-bits. A framing state machine then checks a fixed lead-in, decodes fourteen bi-phase data bits and handles the trailing half. `HALF_CYC` sets how many clock cycles make one half-bit.

When the fourteenth bit is known, the block pulses `frame_valid_o` for one cycle and updates a 16-bit scancode, which it holds until the next good frame. A malformed interval pulses `frame_err_o` for one cycle and drops the machine back to its idle state. A very long interval resynchronises the machine without an error. Holding `enable_i` low parks the machine and silences both strobes.

The states are IDLE, LEAD_MARK, LEAD_SPACE, DATA and TAIL. The transitions are:
- IDLE to LEAD_MARK on any space. A mark in IDLE is ignored.
- LEAD_MARK to LEAD_SPACE on a one-half-bit mark.
- LEAD_SPACE to DATA on a one-half-bit space.
- DATA loops on itself until the last bit is decoded, then goes to TAIL.
- TAIL to IDLE on a mark.
- Any state to IDLE on an error, on a stale interval, or while disabled.

Top module: `ir_rc5_rx`

## Requirements
- R1: After reset, `frame_valid_o` and `frame_err_o` are low, `scancode_o` is 0 and the machine is in IDLE.
- R2: In IDLE a space interval of any length arms the machine and clears the collected bits. A mark interval in IDLE is ignored and raises no error.
- R3: The two lead-in intervals must be a mark and then a space. Each is accepted only if its length d in cycles satisfies floor(HALF_CYC/2) <= d < HALF_CYC + floor(HALF_CYC/2). Any other length or order raises one error pulse and returns to IDLE.
- R4: In DATA each interval is rounded to n = floor((d + floor(HALF_CYC/2)) / HALF_CYC) half-bits. A result of n = 0 or n > 3 raises an error and returns to IDLE.
- R5: The data timeline starts at half-slot 0, which is the mark that follows the lead-in space. Data bit k occupies half-slots 2k+1 and 2k+2. A bit is 1 when its first half is a space and 0 when its first half is a mark. An interval that spans both halves of one bit (every n = 3 interval included) is an error.
- R6: Data bit k, counted from 0 in time order, goes to address bit k for k < 8 and to command bit k-8 for k >= 8. `scancode_o[15:8]` is the address, `scancode_o[7:6]` is 0 and `scancode_o[5:0]` is the command.
- R7: When the first half of bit 13 has been classified, `frame_valid_o` pulses for exactly one cycle and `scancode_o` takes the new value. The scancode does not change at any other time. A later frame does not inherit bits from an earlier one.
- R8: In TAIL a mark returns the machine silently to IDLE. A space that is not stale raises an error.
- R9: An interval longer than 2·14·HALF_CYC + floor(HALF_CYC/2) cycles is stale. A stale interval is handled as if the machine were in IDLE, without an error, so a stale space arms a new frame. The duration counter saturates rather than wrapping.
- R10: While `enable_i` is low the machine stays in IDLE and neither strobe is raised.
- R11: `frame_err_o` lasts one cycle and never coincides with `frame_valid_o`.
- R12: For even HALF_CYC, a frame in which every interval is offset by the same j cycles decodes correctly exactly when -HALF_CYC/2 <= j < HALF_CYC/2. Outside that range it raises an error and produces no scancode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Decoder enable; low holds the machine in IDLE |
| ir_level_i | input | 1 | Asynchronous detector level, 1 = mark |
| frame_valid_o | output | 1 | One-cycle strobe when a frame completes |
| frame_err_o | output | 1 | One-cycle strobe on a timing or ordering fault |
| scancode_o | output | 16 | Address in [15:8] and command in [5:0] |

## Verification
The bench builds the receiver with HALF_CYC = 16. That makes a half-bit 16 cycles, makes the stale limit 456 cycles and makes the acceptance windows short enough to sweep cycle by cycle. The sweeps cover:
- every lead-in length from 4 to 28 cycles;
- a uniform jitter from -10 to +9 cycles;
- stale-limit gaps of 455 to 458 cycles;
- first-data-interval lengths across the rounding thresholds.

All fourteen single-bit codes, the extreme codes and a pseudo-random set of codes run in well under the cycle budget.

// File: rtl/ir_rc5_pkg.sv
`timescale 1ns/1ps
package ir_rc5_pkg;

    typedef enum logic [2:0] {
        FR_IDLE       = 3'd0,
        FR_LEAD_MARK  = 3'd1,
        FR_LEAD_SPACE = 3'd2,
        FR_DATA       = 3'd3,
        FR_TAIL       = 3'd4
    } frame_state_e;

    // Classification of one finished mark or space interval.
    typedef struct packed {
        logic       half_ok;  // inside the single half-bit window
        logic       run_ok;   // rounds to 1..3 half-bits
        logic [1:0] halves;   // rounded half-bit count (valid when run_ok)
        logic       stale;    // longer than one frame plus half a half-bit
    } span_class_t;

endpackage

// File: rtl/ir_level_sync.sv
`timescale 1ns/1ps
module ir_level_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic edge_o,
    output logic ended_mark_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   settled_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q   <= '0;
            settled_q <= 1'b0;
        end else begin
            chain_q   <= {chain_q[SYNC_STAGES-2:0], level_i};
            settled_q <= chain_q[SYNC_STAGES-1];
        end
    end

    // An interval ends when the synchronised level departs from the held one;
    // the polarity of the finished interval is the held level.
    assign edge_o       = chain_q[SYNC_STAGES-1] ^ settled_q;
    assign ended_mark_o = settled_q;

endmodule

// File: rtl/ir_interval_timer.sv
`timescale 1ns/1ps
module ir_interval_timer #(
    parameter int CNT_W = 10,
    parameter int SAT   = 600
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_i,
    output logic [CNT_W-1:0] dur_o
);

    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

    logic [CNT_W-1:0] count_q;

    // Starts saturated so the first interval after reset is treated as stale.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= SAT_V;
        end else if (edge_i) begin
            count_q <= CNT_W'(1);
        end else if (count_q != SAT_V) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign dur_o = count_q;

    a_r9_counter_holds_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dur_o == SAT_V && !edge_i) |=> dur_o == SAT_V)
        else $error("R9: duration counter left saturation");

    a_r9_counter_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_i |=> dur_o == CNT_W'(1))
        else $error("R9: duration counter did not restart");

    a_r9_counter_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dur_o <= SAT_V)
        else $error("R9: duration counter beyond limit");

endmodule

// File: rtl/ir_halfbit_quant.sv
`timescale 1ns/1ps
module ir_halfbit_quant
    import ir_rc5_pkg::*;
#(
    parameter int HALF_CYC  = 16,
    parameter int CNT_W     = 10,
    parameter int STALE_LIM = 456,
    parameter int MAX_RUN   = 3
) (
    input  logic [CNT_W-1:0] dur_i,
    output span_class_t      span_o
);

    localparam int HH = HALF_CYC / 2;
    localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(HH);
    localparam logic [CNT_W-1:0] WIN_HI  = CNT_W'(HALF_CYC + HH);
    localparam logic [CNT_W-1:0] STALE_V = CNT_W'(STALE_LIM);

    // at_least[k-1]: the interval rounds to k or more half-bits
    logic [MAX_RUN:0] at_least;

    for (genvar k = 1; k <= MAX_RUN + 1; k++) begin : g_thresh
        localparam logic [CNT_W-1:0] EDGE_V = CNT_W'(k * HALF_CYC - HH);
        assign at_least[k-1] = (dur_i >= EDGE_V);
    end

    always_comb begin
        logic [1:0] tally;
        tally = 2'd0;
        for (int k = 0; k < MAX_RUN; k++) begin
            if (at_least[k]) tally = tally + 2'd1;
        end
        span_o.half_ok = (dur_i >= WIN_LO) && (dur_i < WIN_HI);
        span_o.run_ok  = at_least[0] && !at_least[MAX_RUN];
        span_o.halves  = tally;
        span_o.stale   = (dur_i > STALE_V);
    end

endmodule

// File: rtl/ir_frame_fsm.sv
`timescale 1ns/1ps
module ir_frame_fsm
    import ir_rc5_pkg::*;
#(
    parameter int FRAME_BITS = 14,
    parameter int ADDR_BITS  = 8,
    parameter int CODE_W     = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              ev_i,
    input  logic              ev_mark_i,
    input  span_class_t       span_i,
    output logic              valid_o,
    output logic              err_o,
    output logic [CODE_W-1:0] code_o
);

    localparam int SLOTS     = 2 * FRAME_BITS;
    localparam int POS_W     = $clog2(SLOTS + 1);
    localparam int IDX_W     = POS_W - 1;
    localparam int CMD_BITS  = FRAME_BITS - ADDR_BITS;
    localparam int CMD_FIELD = CODE_W - ADDR_BITS;

    frame_state_e            state_q, state_d, cur_s;
    logic [POS_W-1:0]        pos_q, pos_d, odd_slot;
    logic [FRAME_BITS-1:0]   bits_q, bits_d;
    logic [IDX_W-1:0]        bit_idx;
    logic                    done_s, fault_s, clash_s, odd_hit_s;
    logic [CODE_W-1:0]       code_d;
    logic [CMD_BITS-1:0]     cmd_bits;

    // Which odd half-slot (first half of a bit) this interval covers, if any.
    assign clash_s   = (pos_q[0] && span_i.halves >= 2'd2) || (span_i.halves == 2'd3);
    assign odd_hit_s = pos_q[0] || (span_i.halves == 2'd2);
    assign odd_slot  = pos_q[0] ? pos_q : pos_q + POS_W'(1);
    assign bit_idx   = odd_slot[POS_W-1:1];

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        bits_d  = bits_q;
        done_s  = 1'b0;
        fault_s = 1'b0;
        cur_s   = span_i.stale ? FR_IDLE : state_q;
        if (!enable_i) begin
            state_d = FR_IDLE;
        end else if (ev_i) begin
            state_d = cur_s;
            unique case (cur_s)
                FR_IDLE: begin
                    if (!ev_mark_i) begin
                        state_d = FR_LEAD_MARK;
                        pos_d   = '0;
                        bits_d  = '0;
                    end
                end
                FR_LEAD_MARK: begin
                    if (ev_mark_i && span_i.half_ok) state_d = FR_LEAD_SPACE;
                    else                             fault_s = 1'b1;
                end
                FR_LEAD_SPACE: begin
                    if (!ev_mark_i && span_i.half_ok) begin
                        state_d = FR_DATA;
                        pos_d   = '0;
                    end else begin
                        fault_s = 1'b1;
                    end
                end
                FR_DATA: begin
                    if (!span_i.run_ok || clash_s) begin
                        fault_s = 1'b1;
                    end else begin
                        pos_d = pos_q + POS_W'(span_i.halves);
                        if (odd_hit_s) begin
                            bits_d[bit_idx] = ~ev_mark_i;
                            if (bit_idx == IDX_W'(FRAME_BITS - 1)) begin
                                done_s  = 1'b1;
                                state_d = FR_TAIL;
                            end
                        end
                    end
                end
                FR_TAIL: begin
                    if (ev_mark_i) state_d = FR_IDLE;
                    else           fault_s = 1'b1;
                end
                default: state_d = FR_IDLE;
            endcase
            if (fault_s) state_d = FR_IDLE;
        end
    end

    assign cmd_bits = bits_d[FRAME_BITS-1:ADDR_BITS];
    assign code_d   = {bits_d[ADDR_BITS-1:0], CMD_FIELD'(cmd_bits)};

    // State register process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FR_IDLE;
            pos_q   <= '0;
            bits_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            bits_q  <= bits_d;
        end
    end

    // Output process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= done_s;
            err_o   <= fault_s;
            if (done_s) code_o <= code_d;
        end
    end

    a_r11_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_o && err_o))
        else $error("R11: valid and error together");

    a_r7_valid_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o)
        else $error("R7: valid longer than one cycle");

    a_r11_err_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> !err_o)
        else $error("R11: error longer than one cycle");

    a_r10_disable_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!valid_o && !err_o && state_q == FR_IDLE))
        else $error("R10: activity while disabled");

    a_r7_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> $stable(code_o))
        else $error("R7: scancode changed without valid");

    a_r8_valid_enters_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> state_q == FR_TAIL)
        else $error("R8: completion did not enter TAIL");

    a_r3_err_returns_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> state_q == FR_IDLE)
        else $error("R3: fault did not return to IDLE");

    a_r5_slot_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == FR_DATA |-> pos_q < POS_W'(SLOTS))
        else $error("R5: half-slot position past frame end");

endmodule

// File: rtl/ir_rc5_rx.sv
`timescale 1ns/1ps
module ir_rc5_rx
    import ir_rc5_pkg::*;
#(
    parameter int HALF_CYC    = 177778,
    parameter int FRAME_BITS  = 14,
    parameter int ADDR_BITS   = 8,
    parameter int CODE_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              ir_level_i,
    output logic              frame_valid_o,
    output logic              frame_err_o,
    output logic [CODE_W-1:0] scancode_o
);

    localparam int STALE_LIM = 2 * FRAME_BITS * HALF_CYC + HALF_CYC / 2;
    localparam int SAT       = STALE_LIM + 1;
    localparam int CNT_W     = $clog2(SAT + 1);

    logic             edge_s;
    logic             ended_mark_s;
    logic [CNT_W-1:0] dur_s;
    span_class_t      span_s;

    ir_level_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .level_i      (ir_level_i),
        .edge_o       (edge_s),
        .ended_mark_o (ended_mark_s)
    );

    ir_interval_timer #(
        .CNT_W (CNT_W),
        .SAT   (SAT)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .edge_i (edge_s),
        .dur_o  (dur_s)
    );

    ir_halfbit_quant #(
        .HALF_CYC  (HALF_CYC),
        .CNT_W     (CNT_W),
        .STALE_LIM (STALE_LIM),
        .MAX_RUN   (3)
    ) u_quant (
        .dur_i  (dur_s),
        .span_o (span_s)
    );

    ir_frame_fsm #(
        .FRAME_BITS (FRAME_BITS),
        .ADDR_BITS  (ADDR_BITS),
        .CODE_W     (CODE_W)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (enable_i),
        .ev_i      (edge_s),
        .ev_mark_i (ended_mark_s),
        .span_i    (span_s),
        .valid_o   (frame_valid_o),
        .err_o     (frame_err_o),
        .code_o    (scancode_o)
    );

endmodule

// File: tb/tb_ir_rc5_rx.sv
`timescale 1ns/1ps
module tb_ir_rc5_rx;

    localparam int H    = 16;
    localparam int HH   = H / 2;
    localparam int IDLE = 520;     // above the stale limit 2*14*H + HH = 456

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        ir = 1'b0;
    logic        valid;
    logic        err;
    logic [15:0] code;

    int n_checks = 0;
    int n_err    = 0;
    int vcnt     = 0;
    int ecnt     = 0;
    int v0       = 0;
    int e0       = 0;
    logic [15:0] last_code = 16'h0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ir_rc5_rx #(.HALF_CYC(H)) dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .enable_i      (en),
        .ir_level_i    (ir),
        .frame_valid_o (valid),
        .frame_err_o   (err),
        .scancode_o    (code)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid) begin
                vcnt = vcnt + 1;
                last_code = code;
            end
            if (err) ecnt = ecnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] expcode(input logic [13:0] c);
        return {c[7:0], 2'b00, c[13:8]};
    endfunction

    task automatic hold(input logic lv, input int d);
        ir = lv;
        repeat (d) @(negedge clk);
    endtask

    // lm/ls: lead mark/space lengths; d0 > 0 overrides the first data run.
    task automatic send_frame(input logic [13:0] c, input int jit, input int lm,
                              input int ls, input int d0, input int tail);
        logic lv [0:30];
        int i;
        int run;
        lv[0] = 1'b1; lv[1] = 1'b0; lv[2] = 1'b1;
        for (int k = 0; k < 14; k++) begin
            lv[3 + 2 * k] = ~c[k];
            lv[4 + 2 * k] = c[k];
        end
        i = 0;
        run = 0;
        while (i < 31) begin
            int j;
            int dur;
            j = i;
            while (j < 31 && lv[j] == lv[i]) j++;
            if (run == 0)                 dur = lm;
            else if (run == 1)            dur = ls;
            else if (run == 2 && d0 > 0)  dur = d0;
            else                          dur = (j - i) * H + jit;
            if (!(j == 31 && lv[i] == 1'b0)) hold(lv[i], dur);
            i = j;
            run++;
        end
        hold(1'b0, tail);
    endtask

    task automatic send_std(input logic [13:0] c);
        send_frame(c, 0, H, H, 0, IDLE);
    endtask

    task automatic snap();
        v0 = vcnt;
        e0 = ecnt;
    endtask

    task automatic expect_ok(input string req, input logic [13:0] c, input int nv);
        chk((vcnt - v0) == nv && (ecnt - e0) == 0, req, "valid count (errors must be 0)",
            (vcnt - v0) * 100 + (ecnt - e0), nv * 100);
        chk(last_code == expcode(c), req, "scancode", int'(last_code), int'(expcode(c)));
    endtask

    task automatic expect_bad(input string req);
        chk((vcnt - v0) == 0, req, "valid count on bad frame", vcnt - v0, 0);
        chk((ecnt - e0) >= 1, req, "error count on bad frame", ecnt - e0, 1);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [13:0] c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk(valid == 1'b0, "R1", "valid after reset", int'(valid), 0);
        chk(err == 1'b0, "R1", "err after reset", int'(err), 0);
        chk(code == 16'h0, "R1", "scancode after reset", int'(code), 0);

        // R5 R6 R7: single-bit codes, extreme and alternating codes
        for (int b = 0; b < 14; b++) begin
            c = 14'(1) << b;
            snap(); send_std(c); expect_ok("R6", c, 1);
        end
        snap(); send_std(14'h0000); expect_ok("R7", 14'h0000, 1);
        snap(); send_std(14'h3FFF); expect_ok("R5", 14'h3FFF, 1);
        snap(); send_std(14'h2AAA); expect_ok("R5", 14'h2AAA, 1);
        snap(); send_std(14'h1555); expect_ok("R5", 14'h1555, 1);

        // R6: pseudo-random codes
        lfsr = 16'hACE1;
        for (int n = 0; n < 16; n++) begin
            lfsr = (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0000);
            c = lfsr[13:0];
            snap(); send_std(c); expect_ok("R6", c, 1);
        end

        // R12: uniform jitter sweep
        for (int j = -10; j <= 9; j++) begin
            snap();
            send_frame(14'h2D5B, j, H + j, H + j, 0, IDLE);
            if (j >= -HH && j < HH) expect_ok("R12", 14'h2D5B, 1);
            else                    expect_bad("R12");
        end

        // R3: lead mark and lead space length windows
        for (int d = 4; d <= 28; d++) begin
            snap();
            send_frame(14'h1235, 0, d, H, 0, IDLE);
            if (d >= HH && d < H + HH) expect_ok("R3", 14'h1235, 1);
            else                       expect_bad("R3");
        end
        for (int d = 4; d <= 28; d++) begin
            snap();
            send_frame(14'h0C71, 0, H, d, 0, IDLE);
            if (d >= HH && d < H + HH) expect_ok("R3", 14'h0C71, 1);
            else                       expect_bad("R3");
        end

        // R4 R5: first data interval rounding (bit 0 = 1, so nominal run is one half)
        snap(); send_frame(14'h1235, 0, H, H, 5, IDLE);  expect_bad("R4");
        snap(); send_frame(14'h1235, 0, H, H, 7, IDLE);  expect_bad("R4");
        snap(); send_frame(14'h1235, 0, H, H, 8, IDLE);  expect_ok("R4", 14'h1235, 1);
        snap(); send_frame(14'h1235, 0, H, H, 23, IDLE); expect_ok("R4", 14'h1235, 1);
        snap(); send_frame(14'h1235, 0, H, H, 40, IDLE); expect_bad("R5");
        snap(); send_frame(14'h1235, 0, H, H, 55, IDLE); expect_bad("R5");
        snap(); send_frame(14'h1235, 0, H, H, 56, IDLE); expect_bad("R4");
        snap(); send_frame(14'h1235, 0, H, H, 70, IDLE); expect_bad("R4");

        // R9: stale boundary on a gap inside a frame
        for (int d = 455; d <= 458; d++) begin
            snap();
            hold(1'b1, H); hold(1'b0, H); hold(1'b1, H);
            hold(1'b0, d);
            send_std(14'h0F0F);
            if (d > 456) expect_ok("R9", 14'h0F0F, 1);
            else         expect_bad("R9");
        end

        // R8: trailing mark returns to IDLE, short space then arms next frame
        snap();
        send_frame(14'h2001, 0, H, H, 0, 40);
        send_std(14'h0333);
        expect_ok("R8", 14'h0333, 2);

        // R8 R2: space in TAIL is an error; the following mark in IDLE is ignored
        snap();
        send_frame(14'h0001, 0, H, H, 0, 40);
        hold(1'b1, H);
        hold(1'b0, IDLE);
        chk((vcnt - v0) == 1, "R8", "valid count before trailer space", vcnt - v0, 1);
        chk((ecnt - e0) == 1, "R2", "errors for trailer space plus idle mark", ecnt - e0, 1);
        chk(last_code == expcode(14'h0001), "R8", "scancode", int'(last_code),
            int'(expcode(14'h0001)));

        // R10: disabled decoder is silent for good and bad frames
        en = 1'b0;
        snap();
        send_std(14'h1111);
        send_frame(14'h1235, 0, 3, H, 0, IDLE);
        chk((vcnt - v0) == 0, "R10", "valid while disabled", vcnt - v0, 0);
        chk((ecnt - e0) == 0, "R10", "error while disabled", ecnt - e0, 0);
        chk(code == expcode(14'h0001), "R10", "scancode held while disabled", int'(code),
            int'(expcode(14'h0001)));
        en = 1'b1;
        hold(1'b0, 20);
        snap(); send_std(14'h2222); expect_ok("R10", 14'h2222, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule